// File: doc/BRIEF.md
# Infrared Pulse Line Codec

This block sits between a UART bit engine and the serial pins. On transmit it takes the NRZ bit stream and, in one of the infrared modes, turns each zero bit into a short high pulse at the start of the bit cell. A one bit keeps the line low. On receive it turns such pulses back into NRZ levels. A configuration byte selects the line mode: plain pass-through, a 3-tick pulse (3/16 of a bit), or a 4-tick pulse (1/4 of a bit). The same byte inverts the transmit pin and the receive pin, each on its own and in every mode.

All timing is counted in ticks of a 16x oversampling strobe supplied by the baud generator. The transmit bit cell is re-aligned on the falling edge of the outgoing start bit. The bit and pin signals are sampled line levels, not a data stream, so there is no valid/ready handshake and no back-pressure. The UART engine owns the bit timing, and the codec follows it tick by tick. The receive pin is asynchronous and passes through a synchronizer before it is decoded.

Top module: `irda_pulse_codec`

## Requirements
- R1: After reset the configuration reads 0x00, `tx_pin` follows `tx_nrz`, and `rx_nrz` is 1 while the line is idle.
- R2: A write stores bits 0, 1, 3, 4 and 5 of `cfg_wdata`. Bits 7, 6 and 2 always read back as 0, so writing 0xFF reads back 0x3B.
- R3: Pass-through applies when bit 0 is clear, or when bit 0 is set with neither bit 1 nor bit 3 set. In pass-through, `tx_pin` = `tx_nrz` XOR bit 5, and `rx_nrz` equals `rx_pin` XOR bit 4 after a two-clock synchronizer.
- R4: With bit 0 and bit 1 set and bit 3 clear, a zero data bit produces a high pulse of exactly 3 ticks starting at tick 0 of its cell. A one data bit leaves the line low, and the line idles low.
- R5: With bit 0 and bit 3 set, the pulse lasts exactly 4 ticks. This mode wins when bit 1 is also set.
- R6: A bit cell is 16 ticks. A falling edge of `tx_nrz` seen on a tick restarts the cell count, and later cells follow every 16 ticks.
- R7: In the pulse modes, bit 5 inverts the transmit pin: the line idles high and pulses go low.
- R8: In the pulse modes, a rising edge of the decoded receive line drives `rx_nrz` to 0 from the next clock for 17 ticks, which bridges back-to-back zero cells. With no pulse, `rx_nrz` stays 1.
- R9: Bit 4 inverts the receive pin before decoding in every mode. With both inversions set, a looped-back line recovers the original bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| tick16 | input | 1 | 16x oversampling strobe, one clock wide |
| tx_nrz | input | 1 | NRZ bit from the UART transmitter |
| tx_pin | output | 1 | Transmit pin |
| rx_pin | input | 1 | Receive pin (asynchronous) |
| rx_nrz | output | 1 | Recovered NRZ bit to the UART receiver |

## Verification
Whole UART frames (idle, start, eight data bits, stop) are sent through a TX-to-RX loopback. The data bytes mix runs of zeros, runs of ones and alternating bits. Back-to-back zero cells show whether the receive hold bridges adjacent pulses, and isolated ones show whether the hold ends in time. Counting high cycles in each cell separates the 3-tick and 4-tick widths and the pass-through level. The configuration patterns include enable without a select bit, a select bit without enable, and both select bits at once, which checks the mode decode and the priority rule. Single-sided inversions in pass-through check that each inversion acts alone, because the looped-back bit comes out flipped.

// File: rtl/irda_codec_pkg.sv
package irda_codec_pkg;
  typedef enum logic [1:0] {
    MODE_NRZ  = 2'd0,
    MODE_SHRT = 2'd1,
    MODE_QRTR = 2'd2
  } line_mode_e;

  localparam int BIT_EN    = 0;
  localparam int BIT_SHRT  = 1;
  localparam int BIT_QRTR  = 3;
  localparam int BIT_RXINV = 4;
  localparam int BIT_TXINV = 5;

  localparam logic [7:0] CFG_KEEP = 8'b0011_1011;

  typedef struct packed {
    line_mode_e mode;
    logic       tx_inv;
    logic       rx_inv;
  } codec_cfg_t;
endpackage

// File: rtl/irda_cfg_reg.sv
module irda_cfg_reg
  import irda_codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output codec_cfg_t cfg
);
  logic [7:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wdata & CFG_KEEP;
  end

  assign rdata = cfg_q;

  always_comb begin
    cfg.tx_inv = cfg_q[BIT_TXINV];
    cfg.rx_inv = cfg_q[BIT_RXINV];
    if (!cfg_q[BIT_EN])        cfg.mode = MODE_NRZ;
    else if (cfg_q[BIT_QRTR])  cfg.mode = MODE_QRTR;
    else if (cfg_q[BIT_SHRT])  cfg.mode = MODE_SHRT;
    else                       cfg.mode = MODE_NRZ;
  end
endmodule

// File: rtl/irda_tx_shaper.sv
module irda_tx_shaper
  import irda_codec_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int SHRT_TICKS = 3,
  parameter int QRTR_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  line_mode_e mode,
  input  logic       inv,
  input  logic       tx_nrz,
  output logic       tx_pin
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [PH_W-1:0] phase_q;
  logic            cell_bit_q;
  logic            prev_q;
  logic            start_edge;
  logic [PH_W-1:0] width;
  logic            pulse;

  assign start_edge = prev_q & ~tx_nrz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_LAST;
      cell_bit_q <= 1'b1;
      prev_q     <= 1'b1;
    end else if (tick) begin
      prev_q <= tx_nrz;
      if (start_edge) begin
        phase_q    <= '0;
        cell_bit_q <= 1'b0;
      end else if (phase_q == PH_LAST) begin
        phase_q    <= '0;
        cell_bit_q <= tx_nrz;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign width  = (mode == MODE_QRTR) ? PH_W'(QRTR_TICKS) : PH_W'(SHRT_TICKS);
  assign pulse  = ~cell_bit_q & (phase_q < width);
  assign tx_pin = ((mode == MODE_NRZ) ? tx_nrz : pulse) ^ inv;
endmodule

// File: rtl/irda_rx_recover.sv
module irda_rx_recover
  import irda_codec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  line_mode_e mode,
  input  logic       inv,
  input  logic       rx_pin,
  output logic       rx_nrz
);
  localparam int HOLD   = OVS + 1;
  localparam int HOLD_W = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  logic                   prev_q;
  logic [HOLD_W-1:0]      hold_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic d;
    if (s == 0) begin : g_first
      assign d = rx_pin ^ inv;
    end else begin : g_next
      assign d = sync_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b1;
      else        sync_q[s] <= d;
    end
  end

  assign line = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      hold_q <= '0;
    end else begin
      prev_q <= line;
      if (mode == MODE_NRZ)            hold_q <= '0;
      else if (line && !prev_q)        hold_q <= HOLD_W'(HOLD);
      else if (tick && hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end

  assign rx_nrz = (mode == MODE_NRZ) ? line : (hold_q == '0);
endmodule

// File: rtl/irda_pulse_codec.sv
module irda_pulse_codec
  import irda_codec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SHRT_TICKS  = 3,
  parameter int QRTR_TICKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       tick16,
  input  logic       tx_nrz,
  output logic       tx_pin,
  input  logic       rx_pin,
  output logic       rx_nrz
);
  codec_cfg_t cfg;

  irda_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  irda_tx_shaper #(
    .OVS        (OVS),
    .SHRT_TICKS (SHRT_TICKS),
    .QRTR_TICKS (QRTR_TICKS)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .mode   (cfg.mode),
    .inv    (cfg.tx_inv),
    .tx_nrz (tx_nrz),
    .tx_pin (tx_pin)
  );

  irda_rx_recover #(
    .OVS         (OVS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .mode   (cfg.mode),
    .inv    (cfg.rx_inv),
    .rx_pin (rx_pin),
    .rx_nrz (rx_nrz)
  );
endmodule

// File: rtl/irda_codec_chk.sv
module irda_codec_chk #(
  parameter int SHRT_TICKS = 3,
  parameter int QRTR_TICKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_rdata,
  input logic       tick16,
  input logic       tx_nrz,
  input logic       tx_pin,
  input logic       rx_nrz
);
  logic       pulsed;
  logic       lvl;
  logic [4:0] exp_w;
  logic [4:0] hi_ticks;

  assign pulsed = cfg_rdata[0] & (cfg_rdata[1] | cfg_rdata[3]);
  assign lvl    = tx_pin ^ cfg_rdata[5];
  assign exp_w  = cfg_rdata[3] ? 5'(QRTR_TICKS) : 5'(SHRT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_ticks <= '0;
    else if (!pulsed || cfg_we) hi_ticks <= '0;
    else if (!lvl)              hi_ticks <= '0;
    else if (tick16)            hi_ticks <= hi_ticks + 1'b1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] == 1'b0 && cfg_rdata[6] == 1'b0 && cfg_rdata[2] == 1'b0);

  // R3
  passthru_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulsed |-> tx_pin == (tx_nrz ^ cfg_rdata[5]));

  // R4 R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lvl) && pulsed && !cfg_we && $stable(cfg_rdata)) |-> hi_ticks == exp_w);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_nrz) && pulsed && !cfg_we) |=> !rx_nrz);
endmodule

bind irda_pulse_codec irda_codec_chk #(
  .SHRT_TICKS (SHRT_TICKS),
  .QRTR_TICKS (QRTR_TICKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .tick16    (tick16),
  .tx_nrz    (tx_nrz),
  .tx_pin    (tx_pin),
  .rx_nrz    (rx_nrz)
);

// File: tb/irda_pulse_codec_test.sv
module irda_pulse_codec_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       tick16 = 1'b0;
  logic       tx_nrz = 1'b1;
  logic       tx_pin;
  logic       rx_nrz;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irda_pulse_codec uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tick16    (tick16),
    .tx_nrz    (tx_nrz),
    .tx_pin    (tx_pin),
    .rx_pin    (tx_pin),
    .rx_nrz    (rx_nrz)
  );

  // one tick every 4 clocks, 16 ticks = 64 clocks per bit cell
  initial forever begin
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  end

  // {cfg, data byte, pulse ticks (0 = pass-through)}
  localparam logic [18:0] VEC [0:9] = '{
    {8'h00, 8'hA5, 3'd0},  // R3 plain
    {8'h03, 8'h3C, 3'd3},  // R4 short pulse
    {8'h09, 8'hC3, 3'd4},  // R5 quarter pulse
    {8'h0B, 8'h5A, 3'd4},  // R5 priority
    {8'h01, 8'h96, 3'd0},  // R3 enable alone
    {8'h02, 8'h0F, 3'd0},  // R3 select without enable
    {8'h33, 8'h81, 3'd3},  // R7 R9 both inverted
    {8'h39, 8'h7E, 3'd4},  // R7 R9 both inverted
    {8'h20, 8'hF0, 3'd0},  // R3 tx inversion alone
    {8'h10, 8'h55, 3'd0}   // R9 rx inversion alone
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one cell right after a tick edge; we are at posedge+2 of a tick edge
  task automatic send_cell(input logic b, input logic [7:0] cfg, input int pw, input string req);
    int hi = 0;
    logic rxs = 1'b0;
    int exp_hi;
    logic exp_rx;
    @(negedge clk);
    tx_nrz = b;
    for (int i = 1; i <= 64; i++) begin
      @(posedge clk);
      #2;
      if ((tx_pin ^ cfg[5]) == 1'b1) hi++;
      if (i == 40) rxs = rx_nrz;
    end
    exp_hi = (pw == 0) ? (b ? 64 : 0) : (b ? 0 : pw * 4);
    exp_rx = (pw == 0) ? (b ^ cfg[5] ^ cfg[4]) : b;
    check(hi == exp_hi, {req, " R6 pulse width"}, hi, exp_hi);
    check(rxs == exp_rx, {req, " R8 loopback"}, rxs, exp_rx);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 8'h00, "R1 cfg after reset", cfg_rdata, 0);
    check(rx_nrz == 1'b1, "R1 rx idle", rx_nrz, 1);
    tx_nrz = 1'b0;
    #1;
    check(tx_pin == 1'b0, "R1 tx follows", tx_pin, 0);
    tx_nrz = 1'b1;
    rst_n = 1'b1;

    // R2 reserved bits read zero
    write_cfg(8'hFF);
    @(negedge clk);
    check(cfg_rdata == 8'h3B, "R2 readback", cfg_rdata, 8'h3B);
    write_cfg(8'h00);
    @(negedge clk);
    check(cfg_rdata == 8'h00, "R2 clear", cfg_rdata, 0);

    // R4 idle line low in pulse mode, R8 no pulse keeps rx at 1
    write_cfg(8'h03);
    begin
      int hi = 0;
      int lo_rx = 0;
      for (int i = 0; i < 80; i++) begin
        @(posedge clk);
        #2;
        if (tx_pin) hi++;
        if (!rx_nrz) lo_rx++;
      end
      check(hi == 0, "R4 idle low", hi, 0);
      check(lo_rx == 0, "R8 no pulse rx high", lo_rx, 0);
    end

    // table of frames through the loopback
    for (int v = 0; v < 10; v++) begin
      logic [7:0] c;
      logic [7:0] d;
      int pw;
      c  = VEC[v][18:11];
      d  = VEC[v][10:3];
      pw = int'(VEC[v][2:0]);
      write_cfg(c);
      @(posedge clk);
      while (!tick16) @(posedge clk);
      #2;
      send_cell(1'b1, c, pw, "R3 idle");
      send_cell(1'b1, c, pw, "R3 idle");
      send_cell(1'b0, c, pw, (pw == 0) ? "R3 start" : (pw == 3 ? "R4 start" : "R5 start"));
      for (int k = 0; k < 8; k++)
        send_cell(d[k], c, pw, (pw == 0) ? "R9 data" : (c[5] ? "R7 data" : "R5 data"));
      send_cell(1'b1, c, pw, "R6 stop");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule